// File: doc/BRIEF.md
# Two-Wire Half-Duplex Register Slave

This block is the device side of a synchronous serial port made of one host-driven clock line and one shared data line. Each exchange takes exactly sixteen clock pulses. The first pulse carries a direction flag. The next seven carry a register address. The last eight carry a data byte, which the host supplies on a write and the block returns on a read. Both lines come from another clock domain. They are brought into the system clock domain through a two-stage synchronizer, and edges are found only after synchronization. The shared line is modelled as three signals: a sampled input, an output value and an output enable.

Behind the port sits a small register file:
- A control register with three bits: a self-clearing soft reset, power-down and forced-awake.
- A read-only status byte and an inverted identity byte.
- Two signed motion accumulators, fed from input ports and cleared when read.
- A 16-bit exposure value. Reading its upper byte freezes its lower byte.

A watchdog counted in system clocks abandons an exchange that stalls. While the block is powered down, the watchdog stops counting, the line is never driven, and control writes change only the power-down bit.

Top module: `serial_reg_slave`

## Requirements
- R1: The data line is sampled on each rising clock edge. The first bit sets the direction: 1 means write, 0 means read. It is followed by the address, MSB first, and then the data byte, MSB first. A value written to the control register reads back unchanged through the same framing.
- R2: On a read, `sdio_oe` rises in response to the 8th rising edge and presents D7. The following bits change only on falling edges. D0 is held after the 16th rising edge until the next falling edge, and `sdio_oe` is then cleared.
- R3: A 16-edge exchange may fail to complete within `TIMEOUT_CYC` system clocks of its first rising edge. In that case the bit counter returns to idle, and the next exchange is decoded from its first bit.
- R4: A write to an address with no register changes nothing. A read from such an address returns 0x00.
- R5: The control register at address 0x00 has power-down in bit 6 and forced-awake in bit 0. Each bit drives the output of the same name. The register reads back as {0, bit 6, 00000, bit 0}.
- R6: Outside power-down, a control write with bit 7 set does the following:
  - clears both motion accumulators;
  - sets the exposure value to 0x0100;
  - clears the frozen low byte;
  - loads bits 6 and 0 from the written byte.
  Bit 7 always reads back as 0.
- R7: While `power_down` is 1:
  - a control write changes only bit 6, so bit 7 and bit 0 are ignored;
  - the data line is never driven;
  - reads have no side effects;
  - the watchdog does not count.
- R8: Address 0x01 reads as bits [7:1] = 0 with bit 0 = `awake_in | forced_awake`. Address 0x11 reads 0x0F.
- R9: Address 0x02 holds Y motion and address 0x03 holds X motion, both as 8-bit two's complement. Each `frame_valid` pulse adds `dy_in` and `dx_in`, saturating at 0x7F and 0x80. A read returns the sum and clears it.
- R10: The 16-bit exposure value is loaded from `shutter_in` on each `frame_valid`. Reading 0x09 returns the upper byte and captures the lower byte. Reading 0x0A returns that captured byte, even if the value has changed since.
- R11: After reset:
  - `sdio_oe`, `power_down` and `forced_awake` are 0;
  - the exposure value is 0x0100 and the frozen low byte is 0x00;
  - both accumulators are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_in | input | 1 | Serial clock from the host (idles high) |
| sdio_in | input | 1 | Sampled level of the shared data line |
| sdio_out | output | 1 | Value the block drives onto the data line |
| sdio_oe | output | 1 | Output enable for the data line |
| frame_valid | input | 1 | One-cycle strobe: new motion and exposure inputs |
| dy_in | input | 8 | Signed Y motion of the current frame |
| dx_in | input | 8 | Signed X motion of the current frame |
| shutter_in | input | 16 | Exposure value of the current frame |
| awake_in | input | 1 | Awake state from the power manager |
| power_down | output | 1 | Control bit 6 |
| forced_awake | output | 1 | Control bit 0 |

## Verification
A table of exchanges tests the framing. It mixes writes and reads to implemented, unimplemented and read-only addresses, so the results separate address decoding from direction handling and from the data bit order. Directed sequences cover the remaining behaviour:
- Positive and negative motion sums, which show saturation apart from plain wrap-around.
- An exposure change between the upper and lower reads, which shows capture apart from a live read.
- A stalled exchange, which tests the watchdog recovery.
- An exchange stalled across a long pause while powered down, which shows a frozen watchdog apart from a running one.
- A read traced edge by edge, which fixes exactly when the line is taken and released.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
// Shared constants for the serial register slave: register addresses,
// fixed read values and reset values. Assumes 7-bit addresses.
package sreg_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int FRAME_BITS = 16;
    localparam int CNT_W = $clog2(FRAME_BITS);

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 7'h00;
    localparam logic [ADDR_W-1:0] ADDR_STAT   = 7'h01;
    localparam logic [ADDR_W-1:0] ADDR_MOT_Y  = 7'h02; // Y then X, consecutive
    localparam logic [ADDR_W-1:0] ADDR_EXP_HI = 7'h09;
    localparam logic [ADDR_W-1:0] ADDR_EXP_LO = 7'h0A;
    localparam logic [ADDR_W-1:0] ADDR_INV_ID = 7'h11;

    localparam logic [DATA_W-1:0] INV_ID_VAL  = 8'h0F;
    localparam logic [15:0]       EXP_RST_VAL = 16'h0100;

    localparam int CTRL_RST_BIT = 7;
    localparam int CTRL_PD_BIT  = 6;
    localparam int CTRL_FA_BIT  = 0;
endpackage

// File: rtl/sreg_sync_edge.sv
`timescale 1ns/1ps
// Brings the serial clock and data line into the system clock domain
// through STAGES flip-flops each, then flags rising and falling edges
// of the synchronized serial clock. Assumes each serial clock phase
// lasts several system clocks.
module sreg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic sdio_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdio_s
);
    logic [STAGES-1:0] sck_ff;
    logic [STAGES-1:0] sd_ff;
    logic              sck_d;

    // Synchronizer chains; both lines idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_ff <= '1;
            sd_ff  <= '1;
            sck_d  <= 1'b1;
        end else begin
            sck_ff <= {sck_ff[STAGES-2:0], sck_in};
            sd_ff  <= {sd_ff[STAGES-2:0], sdio_in};
            sck_d  <= sck_ff[STAGES-1];
        end
    end

    // Edge flags taken from the synchronized clock.
    always_comb begin
        sck_rise = sck_ff[STAGES-1] & ~sck_d;
        sck_fall = ~sck_ff[STAGES-1] & sck_d;
        sdio_s   = sd_ff[STAGES-1];
    end
endmodule

// File: rtl/sreg_frame.sv
`timescale 1ns/1ps
// Frames the 16-bit exchange. Counts rising edges and shifts in bits.
// Issues a read request after the address and a write request after the
// data. Drives the read byte out on falling edges and times out a
// stalled exchange. Assumes the register file answers rd_byte
// combinationally from rd_addr.
module sreg_frame
    import sreg_pkg::*;
#(
    parameter int TIMEOUT_CYC = 2160000,
    parameter int WD_W = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdio_s,
    input  logic              pd,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wdata,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [WD_W-1:0]   wd_cnt
);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] TX_FIRST = CNT_W'(ADDR_W + 2);
    localparam logic [WD_W-1:0]  WD_LIMIT = WD_W'(TIMEOUT_CYC);

    logic [ADDR_W-1:0] shreg;
    logic              dir_q;
    logic [DATA_W-1:0] tx;
    logic              abort;
    logic              hdr_done;
    logic              dat_done;

    // Decode of the current edge against the bit count.
    always_comb begin
        abort    = !pd && (bit_cnt != '0) && (wd_cnt == WD_LIMIT);
        hdr_done = sck_rise && (bit_cnt == HDR_LAST) && !abort;
        dat_done = sck_rise && (bit_cnt == DAT_LAST) && !abort;
        rd_addr  = {shreg[ADDR_W-2:0], sdio_s};
        rd_req   = hdr_done && !shreg[ADDR_W-1] && !pd;
        wr_req   = dat_done && dir_q;
        wdata    = {shreg, sdio_s};
        sdio_out = tx[DATA_W-1];
    end

    // Bit counter and history shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (abort) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[ADDR_W-2:0], sdio_s};
        end
    end

    // Direction and address held for the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            wr_addr <= '0;
        end else if (hdr_done) begin
            dir_q   <= shreg[ADDR_W-1];
            wr_addr <= rd_addr;
        end
    end

    // Watchdog: runs while an exchange is open, frozen in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_cnt <= '0;
        end else if (bit_cnt == '0 || abort) begin
            wd_cnt <= '0;
        end else if (!pd) begin
            wd_cnt <= wd_cnt + 1'b1;
        end
    end

    // Output driver: load on read request, shift on falls, release after D0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdio_oe <= 1'b0;
            tx      <= '0;
        end else if (abort) begin
            sdio_oe <= 1'b0;
        end else if (rd_req) begin
            sdio_oe <= 1'b1;
            tx      <= rd_byte;
        end else if (sck_fall && sdio_oe) begin
            if (bit_cnt == '0) begin
                sdio_oe <= 1'b0;
            end else if (bit_cnt >= TX_FIRST) begin
                tx <= {tx[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/sreg_delta_acc.sv
`timescale 1ns/1ps
// Saturating signed motion accumulator for one axis. A read clear and
// an addition in the same cycle start the sum from zero.
module sreg_delta_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc
);
    logic [W:0] base;
    logic [W:0] sum;

    // Sign-extended sum, one guard bit for overflow.
    always_comb begin
        base = clr ? '0 : {acc[W-1], acc};
        sum  = base + {din[W-1], din};
    end

    // Accumulate with clamping to the signed range.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            acc <= '0;
        end else if (add_en) begin
            if (sum[W] != sum[W-1]) begin
                acc <= {sum[W], {(W-1){~sum[W]}}};
            end else begin
                acc <= sum[W-1:0];
            end
        end else if (clr) begin
            acc <= '0;
        end
    end
endmodule

// File: rtl/sreg_regs.sv
`timescale 1ns/1ps
// Register file: control bits, status, inverted identity, two motion
// accumulators and the exposure value with its frozen low byte.
// Assumes read and write requests are single-cycle pulses.
module sreg_regs
    import sreg_pkg::*;
#(
    parameter int NAX = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_req,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic                      wr_req,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      frame_valid,
    input  logic [NAX-1:0][DATA_W-1:0] d_in,
    input  logic [15:0]               shutter_in,
    input  logic                      awake_in,
    output logic [DATA_W-1:0]         rd_byte,
    output logic                      pd,
    output logic                      fa
);
    logic                       ctrl_wr;
    logic                       soft_rst;
    logic [NAX-1:0]             d_clr;
    logic [NAX-1:0][DATA_W-1:0] d_acc;
    logic [15:0]                expo;
    logic [7:0]                 expo_lo_cap;

    // Control write decode.
    always_comb begin
        ctrl_wr  = wr_req && (wr_addr == ADDR_CTRL);
        soft_rst = ctrl_wr && wdata[CTRL_RST_BIT] && !pd;
    end

    // One accumulator per axis at consecutive addresses.
    for (genvar g = 0; g < NAX; g++) begin : g_axis
        assign d_clr[g] = rd_req && (rd_addr == ADDR_MOT_Y + ADDR_W'(g));
        sreg_delta_acc #(.W(DATA_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .srst   (soft_rst),
            .clr    (d_clr[g]),
            .add_en (frame_valid),
            .din    (d_in[g]),
            .acc    (d_acc[g])
        );
    end

    // Control bits; only power-down is writable while powered down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd <= 1'b0;
            fa <= 1'b0;
        end else if (ctrl_wr) begin
            pd <= wdata[CTRL_PD_BIT];
            if (!pd) fa <= wdata[CTRL_FA_BIT];
        end
    end

    // Exposure value and the low byte frozen by an upper-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            expo        <= EXP_RST_VAL;
            expo_lo_cap <= '0;
        end else begin
            if (frame_valid) expo <= shutter_in;
            if (rd_req && rd_addr == ADDR_EXP_HI) expo_lo_cap <= expo[7:0];
        end
    end

    // Read multiplexer; unknown addresses return zero.
    always_comb begin
        rd_byte = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_byte[CTRL_PD_BIT] = pd;
            rd_byte[CTRL_FA_BIT] = fa;
        end else if (rd_addr == ADDR_STAT) begin
            rd_byte[0] = awake_in | fa;
        end else if (rd_addr == ADDR_EXP_HI) begin
            rd_byte = expo[15:8];
        end else if (rd_addr == ADDR_EXP_LO) begin
            rd_byte = expo_lo_cap;
        end else if (rd_addr == ADDR_INV_ID) begin
            rd_byte = INV_ID_VAL;
        end else begin
            for (int a = 0; a < NAX; a++) begin
                if (rd_addr == ADDR_MOT_Y + ADDR_W'(a)) rd_byte = d_acc[a];
            end
        end
    end
endmodule

// File: rtl/serial_reg_slave.sv
`timescale 1ns/1ps
// Top of the two-wire register slave: synchronizer, exchange framer and
// register file. The shared data line is split into in/out/enable; an
// external pad or the host model combines them.
module serial_reg_slave
    import sreg_pkg::*;
#(
    parameter int TIMEOUT_CYC = 2160000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_in,
    input  logic        sdio_in,
    output logic        sdio_out,
    output logic        sdio_oe,
    input  logic        frame_valid,
    input  logic [7:0]  dy_in,
    input  logic [7:0]  dx_in,
    input  logic [15:0] shutter_in,
    input  logic        awake_in,
    output logic        power_down,
    output logic        forced_awake
);
    localparam int WD_W = $clog2(TIMEOUT_CYC + 1);

    logic              sck_rise;
    logic              sck_fall;
    logic              sdio_s;
    logic              rd_req;
    logic              wr_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_byte;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WD_W-1:0]   wd_cnt;
    logic [1:0][DATA_W-1:0] d_in;

    assign d_in = {dx_in, dy_in};

    sreg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck_in),
        .sdio_in  (sdio_in),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdio_s   (sdio_s)
    );

    sreg_frame #(.TIMEOUT_CYC(TIMEOUT_CYC), .WD_W(WD_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdio_s   (sdio_s),
        .pd       (power_down),
        .rd_byte  (rd_byte),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wdata    (wdata),
        .sdio_out (sdio_out),
        .sdio_oe  (sdio_oe),
        .bit_cnt  (bit_cnt),
        .wd_cnt   (wd_cnt)
    );

    sreg_regs #(.NAX(2)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .wr_req      (wr_req),
        .wr_addr     (wr_addr),
        .wdata       (wdata),
        .frame_valid (frame_valid),
        .d_in        (d_in),
        .shutter_in  (shutter_in),
        .awake_in    (awake_in),
        .rd_byte     (rd_byte),
        .pd          (power_down),
        .fa          (forced_awake)
    );
endmodule

// File: rtl/serial_reg_slave_chk.sv
`timescale 1ns/1ps
// Property checker for serial_reg_slave, attached by the bind below.
// Observes the ports plus the framer's bit and watchdog counters.
module serial_reg_slave_chk #(
    parameter int TIMEOUT_CYC = 2160000,
    parameter int WD_W = 22
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sdio_oe,
    input logic            power_down,
    input logic            forced_awake,
    input logic [3:0]      bit_cnt,
    input logic [WD_W-1:0] wd_cnt
);
    // R2: the line is taken only once the address phase is complete.
    a_r2_drive_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> bit_cnt == 4'd8);

    // R2: the line is given up only when the exchange is closed.
    a_r2_drive_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdio_oe) |-> bit_cnt == 4'd0);

    // R3: an expired watchdog returns the counter to idle.
    a_r3_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_down && bit_cnt != 4'd0 && wd_cnt == WD_W'(TIMEOUT_CYC)) |=> bit_cnt == 4'd0);

    // R3: the watchdog never passes its limit.
    a_r3_wd_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wd_cnt <= WD_W'(TIMEOUT_CYC));

    // R7: never driving while powered down.
    a_r7_no_drive_pd: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> !sdio_oe);

    // R7: forced-awake cannot change while powered down.
    a_r7_fa_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (power_down && $past(power_down)) |-> $stable(forced_awake));

    // R7: watchdog frozen during an open exchange in power-down.
    a_r7_wd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (power_down && $past(power_down) && bit_cnt != 4'd0 && $past(bit_cnt) != 4'd0)
        |-> $stable(wd_cnt));
endmodule

bind serial_reg_slave serial_reg_slave_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .WD_W        (WD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sdio_oe      (sdio_oe),
    .power_down   (power_down),
    .forced_awake (forced_awake),
    .bit_cnt      (bit_cnt),
    .wd_cnt       (wd_cnt)
);

// File: tb/serial_reg_slave_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a table of exchanges walked by one loop, then
// directed tests for motion, exposure, soft reset, power-down, drive
// timing and the watchdog.
module serial_reg_slave_bench;
    localparam int TO_CYC = 300;
    localparam int H = 8;   // system clocks per serial clock phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b1;
    logic        host = 1'b1;
    logic        frame_valid = 1'b0;
    logic [7:0]  dy = '0;
    logic [7:0]  dx = '0;
    logic [15:0] shut = '0;
    logic        awake = 1'b0;
    logic        sdio_out, sdio_oe, power_down, forced_awake;
    logic        line;
    logic        oe_seen = 1'b0;
    logic        done = 1'b0;
    int          checks = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    assign line = sdio_oe ? sdio_out : host;

    always @(negedge clk) if (sdio_oe) oe_seen <= 1'b1;

    serial_reg_slave #(.TIMEOUT_CYC(TO_CYC)) u_serial_reg_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_in       (sck),
        .sdio_in      (line),
        .sdio_out     (sdio_out),
        .sdio_oe      (sdio_oe),
        .frame_valid  (frame_valid),
        .dy_in        (dy),
        .dx_in        (dx),
        .shutter_in   (shut),
        .awake_in     (awake),
        .power_down   (power_down),
        .forced_awake (forced_awake)
    );

    typedef struct packed {
        logic       wr;
        logic [6:0] a;
        logic [7:0] d;   // write data, or expected read value
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b1, 7'h00, 8'h01},  // R5 set forced-awake
        '{1'b0, 7'h00, 8'h01},  // R1 R5 read back
        '{1'b0, 7'h01, 8'h01},  // R8 awake flag from forced-awake
        '{1'b1, 7'h00, 8'h00},  // R5 clear
        '{1'b0, 7'h01, 8'h00},  // R8 asleep
        '{1'b0, 7'h11, 8'h0F},  // R8 inverted identity
        '{1'b1, 7'h05, 8'hAA},  // R4 write to a gap
        '{1'b0, 7'h05, 8'h00},  // R4 gap reads zero
        '{1'b0, 7'h09, 8'h01},  // R10 R11 exposure upper at reset
        '{1'b0, 7'h0A, 8'h00},  // R10 R11 frozen lower at reset
        '{1'b0, 7'h02, 8'h00},  // R11 Y motion at reset
        '{1'b0, 7'h7F, 8'h00}   // R4 top address reads zero
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clocks bits first..last of {dir, addr, data}; collects read bits.
    task automatic xfer(input logic wr, input logic [6:0] a, input logic [7:0] d,
                        input int first, input int last, inout logic [7:0] rd);
        logic [15:0] word;
        word = {wr, a, d};
        for (int i = first; i <= last; i++) begin
            sck = 1'b0;
            host = (!wr && i >= 8) ? 1'b1 : word[15-i];
            idle(H);
            if (!wr && i >= 8) rd = {rd[6:0], line};
            sck = 1'b1;
            idle(H);
        end
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] rd = '0;
        xfer(1'b1, a, d, 0, 15, rd);
        idle(2 * H);
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] rd);
        rd = '0;
        xfer(1'b0, a, 8'h00, 0, 15, rd);
        idle(2 * H);
    endtask

    task automatic frame(input logic [7:0] y, input logic [7:0] x, input logic [15:0] s);
        dy = y; dx = x; shut = s;
        frame_valid = 1'b1;
        idle(1);
        frame_valid = 1'b0;
        idle(2);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        idle(5);
        rst_n = 1'b1;
        idle(5);

        // R11 reset state at the ports
        chk("R11 sdio_oe", int'(sdio_oe), 0);
        chk("R11 power_down", int'(power_down), 0);
        chk("R11 forced_awake", int'(forced_awake), 0);

        // Table walk (R1 R4 R5 R8 R10 R11)
        for (int k = 0; k < 12; k++) begin
            if (VEC[k].wr) begin
                wr_reg(VEC[k].a, VEC[k].d);
                if (VEC[k].a == 7'h00)
                    chk($sformatf("R5 vec %0d forced_awake", k), int'(forced_awake), int'(VEC[k].d[0]));
            end else begin
                rd_reg(VEC[k].a, rd);
                chk($sformatf("R1 vec %0d addr 0x%0h", k, VEC[k].a), int'(rd), int'(VEC[k].d));
            end
        end

        // R8 awake input reflected in status
        awake = 1'b1;
        rd_reg(7'h01, rd); chk("R8 awake_in", int'(rd), 8'h01);
        awake = 1'b0;

        // R9 accumulate, read, clear
        frame(8'd5, 8'd100, 16'h1234);
        frame(8'd3, 8'd100, 16'h1234);
        rd_reg(7'h02, rd); chk("R9 Y sum", int'(rd), 8'h08);
        rd_reg(7'h02, rd); chk("R9 Y cleared", int'(rd), 8'h00);
        rd_reg(7'h03, rd); chk("R9 X saturate high", int'(rd), 8'h7F);
        frame(8'd0, 8'h9C, 16'h1234);
        frame(8'd0, 8'h9C, 16'h1234);
        rd_reg(7'h03, rd); chk("R9 X saturate low", int'(rd), 8'h80);

        // R10 upper read freezes lower
        rd_reg(7'h09, rd); chk("R10 upper", int'(rd), 8'h12);
        frame(8'd0, 8'd0, 16'h5678);
        rd_reg(7'h0A, rd); chk("R10 frozen lower", int'(rd), 8'h34);

        // R6 soft reset
        frame(8'd9, 8'd0, 16'h5678);
        wr_reg(7'h00, 8'h81);
        rd_reg(7'h00, rd); chk("R6 control after reset", int'(rd), 8'h01);
        rd_reg(7'h09, rd); chk("R6 exposure upper", int'(rd), 8'h01);
        rd_reg(7'h0A, rd); chk("R6 frozen lower", int'(rd), 8'h00);
        rd_reg(7'h02, rd); chk("R6 Y cleared", int'(rd), 8'h00);
        wr_reg(7'h00, 8'h00);

        // R7 power-down: masked writes, no drive, no read side effects
        frame(8'd7, 8'd0, 16'h0100);
        wr_reg(7'h00, 8'h40);
        chk("R7 power_down set", int'(power_down), 1);
        wr_reg(7'h00, 8'hC1);
        chk("R7 bit0 ignored", int'(forced_awake), 0);
        oe_seen = 1'b0;
        rd_reg(7'h02, rd);
        chk("R7 no drive", int'(oe_seen), 0);
        wr_reg(7'h00, 8'h01);
        chk("R7 bit6 cleared", int'(power_down), 0);
        rd_reg(7'h00, rd); chk("R7 control bit0 kept", int'(rd), 8'h00);
        rd_reg(7'h02, rd); chk("R7 Y kept", int'(rd), 8'h07);

        // R7 watchdog frozen across a long stall while powered down
        wr_reg(7'h00, 8'h40);
        rd = '0;
        xfer(1'b1, 7'h00, 8'h00, 0, 2, rd);
        idle(2 * TO_CYC);
        xfer(1'b1, 7'h00, 8'h00, 3, 15, rd);
        idle(2 * H);
        chk("R7 watchdog frozen", int'(power_down), 0);

        // R2 drive window on a read of 0x0F
        rd = '0;
        xfer(1'b0, 7'h11, 8'h00, 0, 6, rd);
        sck = 1'b0; host = 1'b1; idle(H);
        chk("R2 not driven before 8th edge", int'(sdio_oe), 0);
        sck = 1'b1; idle(H);
        chk("R2 driven after 8th edge", int'(sdio_oe), 1);
        chk("R2 D7 presented", int'(sdio_out), 0);
        xfer(1'b0, 7'h11, 8'h00, 8, 15, rd);
        chk("R2 read byte", int'(rd), 8'h0F);
        chk("R2 held after 16th edge", int'(sdio_oe), 1);
        chk("R2 D0 held", int'(sdio_out), 1);
        sck = 1'b0; idle(H);
        chk("R2 released on fall", int'(sdio_oe), 0);
        sck = 1'b1; idle(2 * H);

        // R3 stalled exchange is abandoned
        rd = '0;
        xfer(1'b1, 7'h00, 8'h01, 0, 4, rd);
        idle(2 * TO_CYC);
        rd_reg(7'h11, rd); chk("R3 resync after timeout", int'(rd), 8'h0F);
        chk("R3 no stray write", int'(forced_awake), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule